// File: doc/BRIEF.md
# 8-bit ALU with status flags

This block is the arithmetic and logic datapath of a small 8-bit accumulator processor. Each cycle it takes an operation code, a register value (the accumulator or an index register), a second operand (memory data or an immediate), and the current status byte. It returns the result byte and an updated status byte. Both are registered, so they appear one clock after the inputs.

Each operation rewrites only its own set of flags and passes every other status bit through unchanged. Subtraction and compare share one adder: the operand is inverted and fed in with a carry. Compare and bit test only affect flags. For them the result output carries the register value unchanged, so the caller has nothing to write back.

Increment, decrement, and the four shift and rotate operations act on the second operand. The caller routes the accumulator or memory data into that input. Decimal arithmetic is not supported.

Top module: `alu8_core`

## Requirements
- R1: While `rst_n` is low, `res_o` and `stat_o` are both 0x00.
- R2: Operation code 0 (add) gives R + M + C, where C is status bit 0. The low 8 bits go to the result and bit 8 goes to carry (bit 0). Overflow (bit 6) is set when R and M have the same sign and the result's sign differs from it.
- R3: Operation code 1 (subtract) gives R + (0xFF − M) + C. The low 8 bits go to the result and bit 8 goes to carry, where 1 means no borrow. Overflow is set when R and M have different signs and the result's sign differs from R's.
- R4: Operation codes 2, 3 and 4 give R AND M, R OR M and R XOR M. Carry and overflow are left as they came in.
- R5: Operation code 7 gives M + 1 and operation code 8 gives M − 1, both modulo 256. Carry and overflow are left unchanged.
- R6: Operation code 5 (compare) returns R unchanged as the result. Carry is set exactly when R ≥ M, unsigned. Zero (bit 1) and negative (bit 7) are taken from the 8-bit value of R − M. Overflow is kept.
- R7: Operation code 6 (bit test) returns R unchanged as the result. Zero is set when R AND M is 0x00. Negative takes M bit 7 and overflow takes M bit 6. Carry is kept.
- R8: Operation code 9 shifts M left and operation code 10 shifts it right. A zero fills the vacated bit and carry receives the bit shifted out. The right shift therefore always clears negative.
- R9: Operation code 11 rotates M left and operation code 12 rotates it right, through carry. The incoming carry fills the vacated bit (bit 0 on a left rotate, bit 7 on a right rotate), and carry receives the bit shifted out.
- R10: For every defined operation code other than 5 and 6, zero is set exactly when the result is 0x00, and negative equals result bit 7.
- R11: Status bits 2, 3, 4 and 5 always pass through from `stat_i` to `stat_o`.
- R12: Operation codes 13, 14 and 15 pass M through to the result and leave the status byte unchanged.
- R13: Outputs change only on a rising clock edge. Each output reflects the inputs present just before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_i | input | 4 | Operation code |
| reg_i | input | 8 | Register operand R (accumulator or index) |
| opnd_i | input | 8 | Second operand M (memory or immediate) |
| stat_i | input | 8 | Incoming status byte |
| res_o | output | 8 | Registered result byte |
| stat_o | output | 8 | Registered updated status byte |

## Verification
The bench targets signed overflow at the 0x7F/0x80 boundary in both add and subtract. A design that used the add sign rule for subtract would flag 0x50 − 0xB0 wrongly. It also covers carry out of 0xFF + 0x01, and borrow on 0x00 − 0x01, where a design that inverted the carry sense would report a borrow as no borrow.

Compare is tested with equal, smaller and larger operands, since an off-by-one in the carry rule shows up only on equality. Rotates are driven with both carry values; a design that treated a rotate as a shift would drop the old carry. Undefined codes and the pass-through status bits are checked for unwanted writes.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

    typedef enum logic [3:0] {
        OP_ADD = 4'd0,
        OP_SUB = 4'd1,
        OP_AND = 4'd2,
        OP_OR  = 4'd3,
        OP_XOR = 4'd4,
        OP_CMP = 4'd5,
        OP_BIT = 4'd6,
        OP_INC = 4'd7,
        OP_DEC = 4'd8,
        OP_SHL = 4'd9,
        OP_SHR = 4'd10,
        OP_ROL = 4'd11,
        OP_ROR = 4'd12
    } alu_op_e;

    localparam int STAT_W = 8;
    localparam int FLG_C  = 0;
    localparam int FLG_Z  = 1;
    localparam int FLG_V  = 6;
    localparam int FLG_N  = 7;

    typedef enum logic [1:0] {
        LG_AND = 2'd0,
        LG_OR  = 2'd1,
        LG_XOR = 2'd2
    } logic_sel_e;

endpackage

// File: rtl/alu8_adder.sv
module alu8_adder #(
    parameter int W = 8
) (
    input  logic [W-1:0] x_i,
    input  logic [W-1:0] y_i,
    input  logic         ci_i,
    output logic [W-1:0] sum_o,
    output logic         co_o,
    output logic         ovf_o
);
    logic [W:0] full;

    always_comb begin
        full  = {1'b0, x_i} + {1'b0, y_i} + {{W{1'b0}}, ci_i};
        sum_o = full[W-1:0];
        co_o  = full[W];
        // same-sign inputs producing a sign flip
        ovf_o = (x_i[W-1] == y_i[W-1]) && (full[W-1] != x_i[W-1]);
    end
endmodule

// File: rtl/alu8_logic.sv
module alu8_logic
    import alu8_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic_sel_e   sel_i,
    output logic [W-1:0] y_o
);
    always_comb begin
        unique case (sel_i)
            LG_OR:   y_o = a_i | b_i;
            LG_XOR:  y_o = a_i ^ b_i;
            default: y_o = a_i & b_i;
        endcase
    end
endmodule

// File: rtl/alu8_shift.sv
module alu8_shift #(
    parameter int W = 8
) (
    input  logic [W-1:0] v_i,
    input  logic         ci_i,
    input  logic         left_i,
    input  logic         rotate_i,
    output logic [W-1:0] y_o,
    output logic         co_o
);
    logic fill;

    always_comb begin
        fill = rotate_i ? ci_i : 1'b0;
        if (left_i) begin
            y_o  = {v_i[W-2:0], fill};
            co_o = v_i[W-1];
        end else begin
            y_o  = {fill, v_i[W-1:1]};
            co_o = v_i[0];
        end
    end
endmodule

// File: rtl/alu8_core.sv
module alu8_core
    import alu8_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [3:0]        op_i,
    input  logic [DATA_W-1:0] reg_i,
    input  logic [DATA_W-1:0] opnd_i,
    input  logic [STAT_W-1:0] stat_i,
    output logic [DATA_W-1:0] res_o,
    output logic [STAT_W-1:0] stat_o
);
    localparam int MSB = DATA_W - 1;

    typedef struct packed {
        logic [DATA_W-1:0] res;
        logic [STAT_W-1:0] stat;
    } alu_state_s;

    alu_state_s        nxt_d, cur_q;
    alu_op_e           op_sel;
    logic [DATA_W-1:0] add_x, add_y, add_sum;
    logic              add_ci, add_co, add_ovf;
    logic_sel_e        lg_sel;
    logic [DATA_W-1:0] lg_y;
    logic              sh_left, sh_rot, sh_co;
    logic [DATA_W-1:0] sh_y;

    assign op_sel = alu_op_e'(op_i);

    // operand steering for the single shared adder
    always_comb begin
        add_x  = reg_i;
        add_y  = opnd_i;
        add_ci = stat_i[FLG_C];
        unique case (op_sel)
            OP_SUB: add_y = ~opnd_i;
            OP_CMP: begin add_y = ~opnd_i; add_ci = 1'b1; end
            OP_INC: begin add_x = opnd_i; add_y = {{(DATA_W-1){1'b0}}, 1'b1}; add_ci = 1'b0; end
            OP_DEC: begin add_x = opnd_i; add_y = {DATA_W{1'b1}}; add_ci = 1'b0; end
            default: ;
        endcase
        unique case (op_sel)
            OP_OR:   lg_sel = LG_OR;
            OP_XOR:  lg_sel = LG_XOR;
            default: lg_sel = LG_AND;
        endcase
        sh_left = (op_sel == OP_SHL) || (op_sel == OP_ROL);
        sh_rot  = (op_sel == OP_ROL) || (op_sel == OP_ROR);
    end

    alu8_adder #(.W(DATA_W)) u_adder (
        .x_i(add_x), .y_i(add_y), .ci_i(add_ci),
        .sum_o(add_sum), .co_o(add_co), .ovf_o(add_ovf)
    );

    alu8_logic #(.W(DATA_W)) u_logic (
        .a_i(reg_i), .b_i(opnd_i), .sel_i(lg_sel), .y_o(lg_y)
    );

    alu8_shift #(.W(DATA_W)) u_shift (
        .v_i(opnd_i), .ci_i(stat_i[FLG_C]), .left_i(sh_left),
        .rotate_i(sh_rot), .y_o(sh_y), .co_o(sh_co)
    );

    // result and flag selection
    always_comb begin
        nxt_d.res  = opnd_i;
        nxt_d.stat = stat_i;
        unique case (op_sel)
            OP_ADD, OP_SUB: begin
                nxt_d.res          = add_sum;
                nxt_d.stat[FLG_C]  = add_co;
                nxt_d.stat[FLG_V]  = add_ovf;
                nxt_d.stat[FLG_Z]  = (add_sum == '0);
                nxt_d.stat[FLG_N]  = add_sum[MSB];
            end
            OP_AND, OP_OR, OP_XOR: begin
                nxt_d.res          = lg_y;
                nxt_d.stat[FLG_Z]  = (lg_y == '0);
                nxt_d.stat[FLG_N]  = lg_y[MSB];
            end
            OP_INC, OP_DEC: begin
                nxt_d.res          = add_sum;
                nxt_d.stat[FLG_Z]  = (add_sum == '0);
                nxt_d.stat[FLG_N]  = add_sum[MSB];
            end
            OP_CMP: begin
                nxt_d.res          = reg_i;
                nxt_d.stat[FLG_C]  = add_co;
                nxt_d.stat[FLG_Z]  = (add_sum == '0);
                nxt_d.stat[FLG_N]  = add_sum[MSB];
            end
            OP_BIT: begin
                nxt_d.res          = reg_i;
                nxt_d.stat[FLG_Z]  = (lg_y == '0);
                nxt_d.stat[FLG_N]  = opnd_i[MSB];
                nxt_d.stat[FLG_V]  = opnd_i[MSB-1];
            end
            OP_SHL, OP_SHR, OP_ROL, OP_ROR: begin
                nxt_d.res          = sh_y;
                nxt_d.stat[FLG_C]  = sh_co;
                nxt_d.stat[FLG_Z]  = (sh_y == '0);
                nxt_d.stat[FLG_N]  = sh_y[MSB];
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    assign res_o  = cur_q.res;
    assign stat_o = cur_q.stat;

endmodule

// File: rtl/alu8_core_chk.sv
module alu8_core_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [3:0]        op_i,
    input logic [DATA_W-1:0] reg_i,
    input logic [DATA_W-1:0] opnd_i,
    input logic [7:0]        stat_i,
    input logic [DATA_W-1:0] res_o,
    input logic [7:0]        stat_o
);
    logic armed_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) armed_q <= 1'b0;
        else        armed_q <= 1'b1;
    end

    always @(posedge clk) begin
        if (!rst_n) assert_reset_clear_R1: assert (res_o == '0 && stat_o == '0);
    end

    assert_ctl_bits_kept_R11: assert property (@(posedge clk) disable iff (!rst_n)
        armed_q |-> stat_o[5:2] == $past(stat_i[5:2]));

    assert_undef_passthru_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && $past(op_i) >= 4'd13) |-> (res_o == $past(opnd_i) && stat_o == $past(stat_i)));

    assert_shr_neg_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && $past(op_i) == 4'd10) |-> !stat_o[7]);

    assert_cmp_carry_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && $past(op_i) == 4'd5) |->
        (stat_o[0] == ($past(reg_i) >= $past(opnd_i)) && res_o == $past(reg_i)
         && stat_o[6] == $past(stat_i[6])));

    assert_bit_copy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && $past(op_i) == 4'd6) |->
        (stat_o[7] == $past(opnd_i[DATA_W-1]) && stat_o[6] == $past(opnd_i[DATA_W-2])
         && stat_o[0] == $past(stat_i[0])));

    assert_logic_cv_kept_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && $past(op_i) >= 4'd2 && $past(op_i) <= 4'd4) |->
        (stat_o[0] == $past(stat_i[0]) && stat_o[6] == $past(stat_i[6])));

    assert_zn_from_result_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && $past(op_i) <= 4'd12 && $past(op_i) != 4'd5 && $past(op_i) != 4'd6) |->
        (stat_o[1] == (res_o == '0) && stat_o[7] == res_o[DATA_W-1]));

endmodule

bind alu8_core alu8_core_chk #(.DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .op_i(op_i), .reg_i(reg_i), .opnd_i(opnd_i),
    .stat_i(stat_i), .res_o(res_o), .stat_o(stat_o)
);

// File: tb/tb_alu8_core.sv
`timescale 1ns/1ps
module tb_alu8_core;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] op_i = '0;
    logic [7:0] reg_i = '0, opnd_i = '0, stat_i = '0;
    logic [7:0] res_o, stat_o;

    int vectors = 0;
    int miscompares = 0;
    logic [15:0] prev_exp;
    bit   have_prev = 0;
    bit   done = 0;

    always #2 clk = ~clk;   // 250 MHz

    alu8_core dut (
        .clk(clk), .rst_n(rst_n), .op_i(op_i), .reg_i(reg_i),
        .opnd_i(opnd_i), .stat_i(stat_i), .res_o(res_o), .stat_o(stat_o)
    );

    // behavioural reference: returns {result, status}
    function automatic logic [15:0] ref_model(int op, int r, int m, int s);
        int c = s & 1;
        int t;
        int res = m;
        int d;
        logic [7:0] st = s[7:0];
        case (op)
            0: begin t = r + m + c; res = t & 255; st[0] = (t > 255);
                     st[6] = ((~(r ^ m)) & (r ^ res) & 128) != 0; end
            1: begin t = r + (255 - m) + c; res = t & 255; st[0] = (t > 255);
                     st[6] = ((r ^ m) & (r ^ res) & 128) != 0; end
            2: res = r & m;
            3: res = r | m;
            4: res = r ^ m;
            5: begin res = r; st[0] = (r >= m); d = (r - m) & 255;
                     st[1] = (d == 0); st[7] = (d >= 128); end
            6: begin res = r; st[1] = ((r & m) == 0); st[7] = (m >= 128);
                     st[6] = ((m / 64) % 2) == 1; end
            7: res = (m + 1) & 255;
            8: res = (m + 255) & 255;
            9:  begin res = (m * 2) & 255;     st[0] = (m >= 128); end
            10: begin res = m / 2;             st[0] = (m % 2) == 1; end
            11: begin res = (m * 2 + c) & 255; st[0] = (m >= 128); end
            12: begin res = m / 2 + c * 128;   st[0] = (m % 2) == 1; end
            default: res = m;
        endcase
        if (op <= 12 && op != 5 && op != 6) begin
            st[1] = (res == 0);
            st[7] = (res >= 128);
        end
        return {res[7:0], st};
    endfunction

    task automatic check(string tag, logic [15:0] got, logic [15:0] exp);
        vectors++;
        if (got !== exp) begin
            miscompares++;
            $display("FAIL %s: got res=%02h stat=%02h expected res=%02h stat=%02h",
                     tag, got[15:8], got[7:0], exp[15:8], exp[7:0]);
        end
    endtask

    // drive at negedge, check hold before the edge and the new value after it
    task automatic apply(int op, int r, int m, int s, string tag);
        logic [15:0] exp;
        @(negedge clk);
        op_i = op[3:0]; reg_i = r[7:0]; opnd_i = m[7:0]; stat_i = s[7:0];
        exp = ref_model(op, r, m, s);
        #1;
        if (have_prev) check("R13 hold", {res_o, stat_o}, prev_exp);
        @(posedge clk); #1;
        check(tag, {res_o, stat_o}, exp);
        prev_exp  = exp;
        have_prev = 1;
    endtask

    task automatic report();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    endtask

    initial begin
        #400000;
        vectors++; miscompares++;
        $display("FAIL watchdog: run hung, got timeout expected completion");
        report();
    end

    initial begin
        op_i = 4'd0; reg_i = 8'h55; opnd_i = 8'hAA; stat_i = 8'hFF;
        repeat (3) @(posedge clk);
        #1 check("R1 reset", {res_o, stat_o}, 16'h0000);
        @(negedge clk) rst_n = 1'b1;

        apply(0, 8'h50, 8'h50, 8'h00, "R2 add signed overflow");
        apply(0, 8'hFF, 8'h01, 8'h00, "R2 add carry out zero");
        apply(0, 8'h7F, 8'h00, 8'h01, "R2 add carry in overflow");
        apply(1, 8'h50, 8'hB0, 8'h01, "R3 sub signed overflow");
        apply(1, 8'h00, 8'h01, 8'h01, "R3 sub borrow");
        apply(1, 8'h80, 8'h01, 8'h00, "R3 sub borrow in");
        apply(2, 8'hF0, 8'h0F, 8'h41, "R4 and zero");
        apply(3, 8'h80, 8'h01, 8'h41, "R4 or");
        apply(4, 8'hFF, 8'h7F, 8'h00, "R4 xor");
        apply(5, 8'h40, 8'h40, 8'h40, "R6 cmp equal");
        apply(5, 8'h10, 8'h20, 8'h01, "R6 cmp less");
        apply(5, 8'hF0, 8'h01, 8'h00, "R6 cmp greater");
        apply(6, 8'h3F, 8'hC0, 8'h01, "R7 bit test");
        apply(6, 8'hFF, 8'h01, 8'h40, "R7 bit nonzero");
        apply(7, 8'h00, 8'hFF, 8'h41, "R5 inc wrap");
        apply(8, 8'h00, 8'h00, 8'h41, "R5 dec wrap");
        apply(9, 8'h00, 8'h80, 8'h00, "R8 shl carry out");
        apply(10, 8'h00, 8'h01, 8'h81, "R8 shr carry out");
        apply(11, 8'h00, 8'h80, 8'h01, "R9 rol carry in");
        apply(12, 8'h00, 8'h01, 8'h01, "R9 ror carry in");
        apply(12, 8'h00, 8'h02, 8'h00, "R9 ror no carry");
        apply(13, 8'h12, 8'h34, 8'hA5, "R12 undefined 13");
        apply(15, 8'h12, 8'h00, 8'h5A, "R12 undefined 15");
        apply(2, 8'h00, 8'h00, 8'h3C, "R11 control bits kept");
        apply(0, 8'h01, 8'h01, 8'h3C, "R10 zn after add");

        for (int i = 0; i < 3000; i++) begin
            apply($urandom_range(0, 15), $urandom_range(0, 255),
                  $urandom_range(0, 255), $urandom_range(0, 255), "R10 random mix");
        end
        report();
    end
endmodule